// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block loads a configuration image into a programmable target that accepts its bitstream one bit at a time on a data pin, qualified by a clock pin driven by the host. After a start pulse it resets the target by holding the active-low program pin low for a fixed number of cycles. It then waits for the target's active-low init pin to go high, which means the target is ready. Next it takes the image bytes from a valid/ready byte stream and clocks each one out, most significant bit first. Finally it keeps pulsing the clock until the target raises done.

A programmable divider sets the width of each half of the configuration clock. Both wait phases are bounded. If either one runs out, a sticky timeout flag is raised and the sequencer goes back to idle. The init and done pins come from another device, so each passes through a two-flop synchroniser before the sequencer uses it. A stream beat marked as erroneous stops the shifting early, and the sequencer moves straight on to the done phase.

Top module: `slave_serial_cfg`

## Requirements
- R1: Out of reset and whenever idle: cfg_prog_n is 1, cfg_cclk is 0, cfg_din is 0, busy is 0; after reset load_ok and timeout_err are 0.
- R2: A start pulse accepted in idle drives cfg_prog_n low for exactly PROG_HOLD clock cycles, then high; cfg_cclk stays low meanwhile.
- R3: After release the sequencer polls the synchronised init pin; if it is not high within INIT_TIMEOUT cycles (default 100000), timeout_err is set, busy drops and no cfg_cclk pulse is issued.
- R4: Every data byte is sent most significant bit first, one bit per cfg_cclk rising edge; cfg_din only changes while cfg_cclk is low, and each clock half lasts CLK_DIV cycles.
- R5: A beat is taken when in_valid and in_ready are both 1 at a rising clk edge; exactly img_len bytes are taken and 8*img_len data pulses are sent; img_len of 0 sends none.
- R6: A taken beat with in_err at 1 is not shifted and ends the shifting at once; the sequencer then goes on to the done phase.
- R7: After the data, cfg_cclk keeps pulsing until the synchronised done pin is high; then load_ok is set and busy drops.
- R8: If done stays low for DONE_TIMEOUT post-data pulses (default 100000), exactly that many pulses are issued, then timeout_err is set and busy drops.
- R9: load_ok and timeout_err stay set until the next accepted start, which clears both; they are never set together.
- R10: A start pulse while busy is ignored: no new program pulse, and the original length is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (ignored while busy) |
| img_len | input | LEN_W | Image length in bytes, taken at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | in_data/in_err are valid |
| in_err | input | 1 | Marks the beat as a source error |
| in_ready | output | 1 | Sequencer takes a beat |
| cfg_prog_n | output | 1 | Active-low program pin to the target |
| cfg_cclk | output | 1 | Configuration clock to the target |
| cfg_din | output | 1 | Serial data to the target |
| cfg_init_n | input | 1 | Target ready pin (asynchronous) |
| cfg_done | input | 1 | Target done pin (asynchronous) |
| busy | output | 1 | A load is in progress |
| load_ok | output | 1 | Sticky: last load saw done |
| timeout_err | output | 1 | Sticky: last load timed out |

## Verification
The bench acts as the target. It rebuilds each byte from cfg_din at every rising cfg_cclk and checks it against a queue of expected bytes. A bit-order or off-by-one-bit fault would show up as byte mismatches, and a wrong byte count would show up as a wrong count of data pulses. It also checks the timeout corners. A missing init must end the load with an error and no clock pulses at all, and a missing done must end it after exactly the post-data pulse limit, so a design with an off-by-one bound is caught. It also checks that a second start during a load does not cause a second program pulse, and that a source-error beat stops the shifting after only the good bytes have gone out.

// File: rtl/slave_serial_cfg.sv
module slave_serial_cfg #(
  parameter int LEN_W        = 24,
  parameter int CLK_DIV      = 3,
  parameter int PROG_HOLD    = 64,
  parameter int INIT_TIMEOUT = 100000,
  parameter int DONE_TIMEOUT = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_err,
  output logic             in_ready,
  output logic             cfg_prog_n,
  output logic             cfg_cclk,
  output logic             cfg_din,
  input  logic             cfg_init_n,
  input  logic             cfg_done,
  output logic             busy,
  output logic             load_ok,
  output logic             timeout_err
);
  localparam int TMAX = (INIT_TIMEOUT > DONE_TIMEOUT) ? INIT_TIMEOUT : DONE_TIMEOUT;
  localparam int CMAX = (TMAX > PROG_HOLD) ? TMAX : PROG_HOLD;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int DW   = $clog2(CLK_DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WINIT, S_FETCH, S_SHIFT, S_FLUSH} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [DW-1:0]    div;
  logic [7:0]       sreg;
  logic [2:0]       bitn;
  logic [LEN_W-1:0] left;
  logic [1:0]       init_q, done_q;
  logic             prog_r, cclk_r;

  wire half_end = (div == DW'(CLK_DIV - 1));

  assign busy       = (st != S_IDLE);
  assign in_ready   = (st == S_FETCH);
  assign cfg_prog_n = prog_r;
  assign cfg_cclk   = cclk_r;
  assign cfg_din    = (st == S_SHIFT) && sreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; div <= '0; sreg <= '0; bitn <= '0; left <= '0;
      init_q <= '0; done_q <= '0; prog_r <= 1'b1; cclk_r <= 1'b0;
      load_ok <= 1'b0; timeout_err <= 1'b0;
    end else begin
      init_q <= {init_q[0], cfg_init_n};
      done_q <= {done_q[0], cfg_done};
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_PROG; cnt <= '0; left <= img_len; prog_r <= 1'b0;
            load_ok <= 1'b0; timeout_err <= 1'b0;
          end
        S_PROG:
          if (cnt == CW'(PROG_HOLD - 1)) begin
            prog_r <= 1'b1; cnt <= '0; st <= S_WINIT;
          end else cnt <= cnt + 1'b1;
        S_WINIT:
          if (init_q[1]) begin
            cnt <= '0; div <= '0;
            st <= (left == '0) ? S_FLUSH : S_FETCH;
          end else if (cnt == CW'(INIT_TIMEOUT - 1)) begin
            timeout_err <= 1'b1; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        S_FETCH:
          if (in_valid) begin
            div <= '0;
            if (in_err) begin
              cnt <= '0; st <= S_FLUSH;
            end else begin
              sreg <= in_data; bitn <= '0; st <= S_SHIFT;
            end
          end
        S_SHIFT:
          if (half_end) begin
            div <= '0;
            if (!cclk_r) cclk_r <= 1'b1;
            else begin
              cclk_r <= 1'b0;
              if (bitn == 3'd7) begin
                left <= left - 1'b1;
                cnt  <= '0;
                st   <= (left == LEN_W'(1)) ? S_FLUSH : S_FETCH;
              end else begin
                bitn <= bitn + 1'b1;
                sreg <= {sreg[6:0], 1'b0};
              end
            end
          end else div <= div + 1'b1;
        S_FLUSH:
          if (done_q[1]) begin
            load_ok <= 1'b1; cclk_r <= 1'b0; st <= S_IDLE;
          end else if (half_end) begin
            div <= '0;
            if (!cclk_r) cclk_r <= 1'b1;
            else begin
              cclk_r <= 1'b0;
              if (cnt == CW'(DONE_TIMEOUT - 1)) begin
                timeout_err <= 1'b1; st <= S_IDLE;
              end else cnt <= cnt + 1'b1;
            end
          end else div <= div + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cfg_prog_n && !cfg_cclk && !cfg_din));
  // R2
  prog_quiet_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_cclk);
  // R4
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));
  // R5
  take_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !cfg_cclk && cfg_prog_n));
  // R7
  ok_ends_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ok) |-> $fell(busy));
  // R9
  ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && !start) |=> load_ok);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !start) |=> timeout_err);
  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && timeout_err));
endmodule

// File: tb/sim_slave_serial_cfg.sv
module sim_slave_serial_cfg;
  localparam int DIVP = 2, HOLD = 5, ITO = 40, DTO = 20;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] img_len = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 0, in_err = 0, in_ready;
  logic cfg_prog_n, cfg_cclk, cfg_din, cfg_init_n = 0, cfg_done = 0;
  logic busy, load_ok, timeout_err;

  slave_serial_cfg #(.LEN_W(16), .CLK_DIV(DIVP), .PROG_HOLD(HOLD),
    .INIT_TIMEOUT(ITO), .DONE_TIMEOUT(DTO)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] expq[$];
  int data_rises = 0, extra = 0, accepted = 0, prog_falls = 0, prog_len = 0, glitches = 0;
  int nbits = 0, init_cnt = 0, init_delay = 6, done_after = 3;
  bit init_en = 1, done_en = 1, prev_cclk = 0, prev_prog = 1, prev_din = 0;
  logic [7:0] bbuf = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (in_valid && in_ready) accepted++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // target model and scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (!cfg_prog_n) begin
      cfg_init_n = 0; cfg_done = 0; init_cnt = 0;
      if (prev_prog) begin prog_falls++; prog_len = 0; end
      prog_len++;
    end else if (init_en && !cfg_init_n) begin
      init_cnt++;
      if (init_cnt >= init_delay) cfg_init_n = 1;
    end
    if (prev_cclk && cfg_cclk && (cfg_din != prev_din)) glitches++;
    if (!prev_cclk && cfg_cclk) begin
      if (expq.size() > 0) begin
        data_rises++;
        bbuf = {bbuf[6:0], cfg_din};
        nbits++;
        if (nbits == 8) begin
          logic [7:0] e;
          e = expq.pop_front();
          nbits = 0;
          chk(bbuf == e, "R4 byte", bbuf, e);
        end
      end else extra++;
    end
    if (cfg_init_n && done_en && extra >= done_after) cfg_done = 1;
    prev_cclk = cfg_cclk; prev_prog = cfg_prog_n; prev_din = cfg_din;
  end

  task automatic clear_stats();
    data_rises = 0; extra = 0; accepted = 0; prog_falls = 0; glitches = 0; nbits = 0;
  endtask

  task automatic kick(input int len);
    img_len = 16'(len); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit e);
    in_data = b; in_err = e; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0; in_err = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
    chk(0, "idle timeout", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_prog_n === 1 && cfg_cclk === 0 && cfg_din === 0, "R1 pins", {cfg_prog_n, cfg_cclk, cfg_din}, 3'b100);
    chk(busy === 0 && load_ok === 0 && timeout_err === 0, "R1 flags", {busy, load_ok, timeout_err}, 0);
    rst_n = 1; @(negedge clk);

    // A: normal load, with a start pulse during the load (R10)
    clear_stats();
    expq = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    kick(4);
    fork
      begin
        send(8'hA5, 0); send(8'h3C, 0); send(8'h01, 0); send(8'h80, 0);
      end
      begin
        repeat (30) @(negedge clk);
        chk(busy === 1, "R10 busy", busy, 1);
        kick(1);
      end
    join
    wait_idle();
    chk(prog_len == HOLD, "R2 hold", prog_len, HOLD);
    chk(prog_falls == 1, "R10 prog pulses", prog_falls, 1);
    chk(accepted == 4, "R5 beats", accepted, 4);
    chk(data_rises == 32, "R5 pulses", data_rises, 32);
    chk(expq.size() == 0, "R4 queue", expq.size(), 0);
    chk(glitches == 0, "R4 din hold", glitches, 0);
    chk(load_ok === 1 && timeout_err === 0, "R7 ok", {load_ok, timeout_err}, 2'b10);
    chk(extra >= done_after, "R7 extra clocks", extra, done_after);

    // B: init never rises
    clear_stats(); init_en = 0;
    kick(3);
    wait_idle();
    chk(timeout_err === 1 && load_ok === 0, "R3 err", {load_ok, timeout_err}, 2'b01);
    chk(data_rises + extra == 0 && accepted == 0, "R3 no clock", data_rises + extra, 0);
    repeat (50) @(negedge clk);
    chk(timeout_err === 1, "R9 sticky", timeout_err, 1);
    init_en = 1;

    // C: done never rises
    clear_stats(); done_en = 0;
    expq = '{8'h5A, 8'hC3};
    kick(2);
    chk(timeout_err === 0, "R9 clear on start", timeout_err, 0);
    send(8'h5A, 0); send(8'hC3, 0);
    wait_idle();
    chk(data_rises == 16, "R5 pulses C", data_rises, 16);
    chk(extra == DTO, "R8 pulse bound", extra, DTO);
    chk(timeout_err === 1 && load_ok === 0, "R8 err", {load_ok, timeout_err}, 2'b01);
    done_en = 1;

    // D: source error beat after two bytes
    clear_stats();
    expq = '{8'h0F, 8'hF0};
    kick(5);
    send(8'h0F, 0); send(8'hF0, 0); send(8'hFF, 1);
    wait_idle();
    chk(accepted == 3, "R6 beats", accepted, 3);
    chk(data_rises == 16, "R6 pulses", data_rises, 16);
    chk(load_ok === 1 && timeout_err === 0, "R6 to done", {load_ok, timeout_err}, 2'b10);

    // E: zero length
    clear_stats();
    kick(0);
    wait_idle();
    chk(accepted == 0 && data_rises == 0, "R5 zero len", accepted + data_rises, 0);
    chk(load_ok === 1, "R7 zero len ok", load_ok, 1);
    chk(cfg_prog_n === 1 && cfg_cclk === 0 && cfg_din === 0, "R1 idle pins", {cfg_prog_n, cfg_cclk, cfg_din}, 3'b100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule